// File: doc/BRIEF.md
# Stepped Core-Voltage Serial Loader

This block takes a requested CPU clock frequency (in kHz) and an optional force flag, converts the frequency into a 12-bit regulator divisor code, and moves the regulator to that code. It does not jump there in one write. Each write may change the code by no more than a fixed delta, so a large voltage change cannot make the supply sag far enough to trip the regulator. Every intermediate code goes out as a complete serial frame to the regulator's DAC.

The serial link has three wires: data, a shift clock, and an active-high load strobe. The load strobe is held low between frames and raised after the twelfth bit to latch the word. All edges on the link are spaced by one bit period. The bit period is a parameter counted in system clock cycles; at a 200 MHz system clock the default gives 1 µs. The block keeps the last code it sent and walks from that code on the next request. A force request sends the target as its first frame. Software or a power-management sequencer issues a request when the CPU frequency changes and waits for `done`.

Top module: `vcore_step_loader`

## Requirements
- R1: The target code is 0xFFF for a requested frequency below 200000 kHz, 0xDE5 from 200000 up to 299999 kHz, and 0x325 at 300000 kHz and above.
- R2: Without force, each frame carries the previous code plus 0x100 when the previous code is more than 0x100 below the target, the previous code minus 0x100 when it is more than 0x100 above the target, and the target otherwise.
- R3: With force set, the first frame of the request carries the target code. Force has no effect on any later frame.
- R4: Frames continue until one carries the target. The last code sent is kept across requests, so a later request walks from it.
- R5: A frame sends 12 bits, most significant bit first, each valid on `psu_data` when `psu_clk` rises. `psu_data` does not change while `psu_clk` is high.
- R6: `psu_clk` stays high for exactly DELAY_CYC cycles per bit. `psu_ld` stays high for exactly DELAY_CYC cycles per frame.
- R7: `psu_ld` rises only after the twelfth clock pulse of a frame and is never high together with `psu_clk`.
- R8: `busy` is high from the cycle after an accepted request until the request completes. A request presented while `busy` is high is ignored and produces no frame.
- R9: `done` pulses high for one cycle in the cycle where the final frame's `psu_ld` falls. `busy` is low in that same cycle.
- R10: After reset the stored code is 0, and `psu_data`, `psu_clk`, `psu_ld`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only while not busy |
| req_khz | input | FREQ_W | Requested CPU frequency in kHz |
| req_force | input | 1 | First frame carries the target directly |
| psu_data | output | 1 | Serial data to the regulator DAC |
| psu_clk | output | 1 | Serial shift clock |
| psu_ld | output | 1 | Load strobe, high pulse latches the word |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when the target code has been loaded |

## Verification
`busy` is due one cycle after the request is sampled, so the bench checks it at the next falling edge. The serial results carry no fixed latency from the request. The monitor therefore decodes them as they occur: it samples on the falling clock edge, captures a bit on each rise of `psu_clk`, and compares each word with the head of an expected queue when `psu_ld` rises. The high time of each strobe is counted in whole cycles and compared with DELAY_CYC. `done` and `busy` are checked in the same cycle that `psu_ld` falls on a final frame, and a frame that appears with an empty queue counts as a failure. That failure is how a request ignored under R8 is seen at the ports.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int unsigned CODE_W = 12;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t STEP_MAX  = 12'h100;
    localparam code_t CODE_SLOW = 12'hFFF;
    localparam code_t CODE_MID  = 12'hDE5;
    localparam code_t CODE_FAST = 12'h325;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DATA,
        PH_RISE,
        PH_FALL,
        PH_LDH,
        PH_LDL
    } phase_e;

    typedef enum logic {
        CT_IDLE,
        CT_SEND
    } ctrl_e;

    typedef struct packed {
        code_t target;
        code_t current;
        code_t word;
    } walk_t;

    // One bounded move of the code toward the target; jump sends the target as-is.
    function automatic code_t step_toward(input code_t cur, input code_t tgt, input logic jump);
        logic [CODE_W:0] cur_w;
        logic [CODE_W:0] tgt_w;
        logic [CODE_W:0] stp_w;
        code_t           res;
        cur_w = {1'b0, cur};
        tgt_w = {1'b0, tgt};
        stp_w = {1'b0, STEP_MAX};
        if (jump)
            res = tgt;
        else if (cur_w + stp_w < tgt_w)
            res = cur + STEP_MAX;
        else if (cur_w > tgt_w + stp_w)
            res = cur - STEP_MAX;
        else
            res = tgt;
        return res;
    endfunction

endpackage

// File: rtl/vstep_lookup.sv
module vstep_lookup
    import vstep_pkg::*;
#(
    parameter int unsigned FREQ_W   = 20,
    parameter int unsigned SLOW_KHZ = 200000,
    parameter int unsigned MID_KHZ  = 300000
) (
    input  logic [FREQ_W-1:0] khz,
    output code_t             code
);
    localparam logic [FREQ_W-1:0] SLOW_LIM = FREQ_W'(SLOW_KHZ);
    localparam logic [FREQ_W-1:0] MID_LIM  = FREQ_W'(MID_KHZ);

    always_comb begin
        if (khz < SLOW_LIM)
            code = CODE_SLOW;
        else if (khz < MID_LIM)
            code = CODE_MID;
        else
            code = CODE_FAST;
    end
endmodule

// File: rtl/vstep_timer.sv
module vstep_timer #(
    parameter int unsigned DELAY_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/vstep_shifter.sv
module vstep_shifter
    import vstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  code_t word,
    input  logic  tick,
    output logic  restart,
    output logic  frame_done,
    output logic  sdata,
    output logic  sclk,
    output logic  sld
);
    localparam int unsigned IDX_W = $clog2(CODE_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    phase_e           phase;
    code_t            shreg;
    logic [IDX_W-1:0] bidx;

    always_comb begin
        restart    = 1'b0;
        frame_done = 1'b0;
        if (phase == PH_IDLE)
            restart = start;
        else if (tick) begin
            if (phase == PH_LDL)
                frame_done = 1'b1;
            else
                restart = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            shreg <= '0;
            bidx  <= '0;
            sdata <= 1'b0;
            sclk  <= 1'b0;
            sld   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    shreg <= word;
                    bidx  <= TOP_IDX;
                    sclk  <= 1'b0;
                    sld   <= 1'b0;
                    phase <= PH_DATA;
                end
                PH_DATA: if (tick) begin
                    sdata <= shreg[CODE_W-1];
                    shreg <= {shreg[CODE_W-2:0], 1'b0};
                    phase <= PH_RISE;
                end
                PH_RISE: if (tick) begin
                    sclk  <= 1'b1;
                    phase <= PH_FALL;
                end
                PH_FALL: if (tick) begin
                    sclk <= 1'b0;
                    if (bidx == '0)
                        phase <= PH_LDH;
                    else begin
                        bidx  <= bidx - 1'b1;
                        phase <= PH_DATA;
                    end
                end
                PH_LDH: if (tick) begin
                    sld   <= 1'b1;
                    phase <= PH_LDL;
                end
                PH_LDL: if (tick) begin
                    sld   <= 1'b0;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vcore_step_loader.sv
module vcore_step_loader
    import vstep_pkg::*;
#(
    parameter int unsigned FREQ_W    = 20,
    parameter int unsigned SLOW_KHZ  = 200000,
    parameter int unsigned MID_KHZ   = 300000,
    parameter int unsigned DELAY_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic              req_force,
    output logic              psu_data,
    output logic              psu_clk,
    output logic              psu_ld,
    output logic              busy,
    output logic              done
);
    ctrl_e  ctrl;
    walk_t  walk;
    logic   start_q;
    logic   busy_q;
    logic   done_q;
    code_t  req_code;
    code_t  first_word;
    code_t  follow_word;
    logic   restart;
    logic   tick;
    logic   frame_done;

    vstep_lookup #(
        .FREQ_W  (FREQ_W),
        .SLOW_KHZ(SLOW_KHZ),
        .MID_KHZ (MID_KHZ)
    ) u_lookup (
        .khz (req_khz),
        .code(req_code)
    );

    vstep_timer #(
        .DELAY_CYC(DELAY_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick)
    );

    vstep_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start_q),
        .word      (walk.word),
        .tick      (tick),
        .restart   (restart),
        .frame_done(frame_done),
        .sdata     (psu_data),
        .sclk      (psu_clk),
        .sld       (psu_ld)
    );

    assign first_word  = step_toward(walk.current, req_code, req_force);
    assign follow_word = step_toward(walk.word, walk.target, 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CT_IDLE;
            walk    <= '0;
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (ctrl)
                CT_IDLE: if (req_valid) begin
                    walk.target <= req_code;
                    walk.word   <= first_word;
                    start_q     <= 1'b1;
                    busy_q      <= 1'b1;
                    ctrl        <= CT_SEND;
                end
                CT_SEND: if (frame_done) begin
                    walk.current <= walk.word;
                    if (walk.word == walk.target) begin
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                        ctrl   <= CT_IDLE;
                    end else begin
                        walk.word <= follow_word;
                        start_q   <= 1'b1;
                    end
                end
                default: ctrl <= CT_IDLE;
            endcase
        end
    end

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/vstep_checker.sv
module vstep_checker (
    input logic clk,
    input logic rst,
    input logic psu_data,
    input logic psu_clk,
    input logic psu_ld,
    input logic busy,
    input logic done
);
    AST_LD_NOT_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
        psu_ld |-> !psu_clk);                                              // R7
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (psu_clk && $past(psu_clk)) |-> $stable(psu_data));                // R5
    AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(psu_clk) |-> $stable(psu_data));                             // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $fell(psu_ld)));                                // R9
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                             // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (!psu_clk && !psu_ld));                       // R8
endmodule

bind vcore_step_loader vstep_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .psu_data(psu_data),
    .psu_clk (psu_clk),
    .psu_ld  (psu_ld),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_vcore_step_loader.sv
module sim_vcore_step_loader;
    localparam int DLY    = 4;
    localparam int FREQ_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [FREQ_W-1:0] req_khz = '0;
    logic              req_force = 1'b0;
    logic              psu_data, psu_clk, psu_ld, busy, done;

    always #2.5 clk = ~clk;

    vcore_step_loader #(.FREQ_W(FREQ_W), .DELAY_CYC(DLY)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_khz(req_khz),
        .req_force(req_force), .psu_data(psu_data), .psu_clk(psu_clk),
        .psu_ld(psu_ld), .busy(busy), .done(done)
    );

    int          n_total = 0;
    int          n_fail  = 0;
    bit          reported = 0;
    logic [11:0] exp_q[$];
    logic [11:0] model_cur = 12'h000;
    string       cur_tag = "R2";
    int          done_cnt = 0;
    int          frame_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        end
        $finish;
    endtask

    function automatic logic [11:0] m_code(input int khz);
        if (khz >= 300000) return 12'h325;
        if (khz >= 200000) return 12'hDE5;
        return 12'hFFF;
    endfunction

    function automatic logic [11:0] m_step(input logic [11:0] c, input logic [11:0] t, input bit f);
        if (f) return t;
        if (int'(c) + 256 < int'(t)) return c + 12'h100;
        if (int'(c) > int'(t) + 256) return c - 12'h100;
        return t;
    endfunction

    // Monitor: decodes the serial link at falling edges and scores each frame.
    logic        p_clk = 0, p_ld = 0;
    logic [11:0] shift_v = '0;
    int          nbits = 0, clk_hi = 0, ld_hi = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (psu_clk) clk_hi++;
            if (psu_ld)  ld_hi++;
            if (!p_clk && psu_clk) begin
                shift_v = {shift_v[10:0], psu_data};
                nbits++;
            end
            if (p_clk && !psu_clk) begin
                chk(clk_hi == DLY, "R6", clk_hi, DLY);
                clk_hi = 0;
            end
            if (!p_ld && psu_ld) begin
                frame_cnt++;
                chk(nbits == 12, "R5", nbits, 12);
                nbits = 0;
                if (exp_q.size() == 0)
                    chk(0, "R8", int'(shift_v), 0);
                else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(shift_v == e, cur_tag, int'(shift_v), int'(e));
                end
            end
            if (p_ld && !psu_ld) begin
                chk(ld_hi == DLY, "R6", ld_hi, DLY);
                ld_hi = 0;
                if (exp_q.size() == 0)
                    chk(done && !busy, "R9", {done, busy}, 2);
                else
                    chk(!done && busy, "R9", {done, busy}, 1);
            end
            p_clk = psu_clk;
            p_ld  = psu_ld;
        end
    end

    // Driver: pushes the expected frames, then issues the request.
    task automatic request(input int khz, input bit frc, input string tag, input bit poke);
        logic [11:0] tgt, c;
        bit          first;
        int          d0;
        while (busy) @(negedge clk);
        tgt = m_code(khz);
        c = model_cur;
        first = 1;
        do begin
            c = m_step(c, tgt, first && frc);
            exp_q.push_back(c);
            first = 0;
        end while (c != tgt);
        model_cur = c;
        cur_tag = tag;
        d0 = done_cnt;
        req_khz = FREQ_W'(khz);
        req_force = frc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req_khz = FREQ_W'(150000);
            req_force = 1'b1;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9", done_cnt - d0, 1);
        chk(!busy && !done, "R9", {busy, done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({psu_data, psu_clk, psu_ld, busy, done} == 5'b0, "R10",
            {psu_data, psu_clk, psu_ld, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({psu_clk, psu_ld, busy} == 3'b0, "R10", {psu_clk, psu_ld, busy}, 0);
        // R10 and R2: walk up from the reset code 0 to 0xFFF
        request(150000, 0, "R2", 0);
        // R2: walk down to 0x325
        request(350000, 0, "R2", 0);
        // R3: forced jump back to 0xFFF in one frame
        request(199999, 1, "R3", 0);
        // R1: band boundaries, forced so each frame is the looked-up code
        request(200000, 1, "R1", 0);
        request(299999, 1, "R1", 0);
        request(300000, 1, "R1", 0);
        request(0, 1, "R1", 0);
        // R4: non-forced walk continues from the last code sent
        request(250000, 0, "R4", 0);
        // R8: second request while busy must not add frames
        request(400000, 0, "R8", 1);
        begin
            int f0;
            f0 = frame_cnt;
            repeat (300) @(negedge clk);
            chk(frame_cnt == f0, "R8", frame_cnt, f0);
        end
        report();
    end
endmodule